// File: doc/BRIEF.md
# Register Rename Unit

This block renames one instruction per clock for a single register class. The two source logical registers are looked up in a map table, which returns their physical registers and the busy state of each. When the instruction writes a destination, the block takes a fresh physical register from a free-list FIFO, writes it into the map, and marks it busy. The physical register that the destination replaced is also reported, so that it can be handed back when the instruction retires. Two side ports change state without renaming anything. The completion port clears a busy bit when a producer finishes execution. The release port appends a retired physical register to the tail of the free list. A processor uses one instance for integer registers and a second for floating-point registers.

The free list is run by a three-state machine. `FL_FULL` is the reset state and means every spare register is queued. `FL_PART` means some registers are queued but not all. `FL_EMPTY` means nothing can be allocated. The transitions are:
- FULL→PART on a pop without a push.
- PART→EMPTY when the last entry is popped.
- PART→FULL when the last slot is filled.
- EMPTY→PART (or EMPTY→FULL when the list holds one slot) on a push.
- FULL→EMPTY on a pop without a push, only when the list holds a single slot.

In every other case the state holds. Logical register 0 is hard-wired: it is never renamed and always reads physical register 0.

Top module: `rename_unit`

## Requirements
- R1: An accepted destination gets the physical register at the head of the free list. After reset the list yields 32, 33, …, 63 in that order.
- R2: Each source port returns the physical register currently mapped to its logical register, together with that physical register's busy bit.
- R3: After an accepted rename, the destination's logical register maps to the new physical register from the next cycle on.
- R4: A newly allocated physical register reads busy from the next cycle. A completion clears that bit from the next cycle.
- R5: After reset, logical register i maps to physical register i and no mapped register is busy.
- R6: `ren_stall` is 1 exactly when `ren_valid`, `ren_has_dst` and a non-zero `ren_dst` coincide with a free list that was empty at the start of the cycle. A release in the same cycle does not end the stall. A stalled rename changes no state.
- R7: Logical register 0 is never renamed, and a source naming it reads physical register 0 as not busy.
- R8: A source lookup sees the map as it was before this instruction's own destination update. An instruction that reads and writes the same register therefore gets the old mapping.
- R9: A released physical register joins the tail of the free list and can be allocated from the next cycle.
- R10: `ren_dst_old_phys` gives the mapping that the destination held before the rename, whenever a non-zero destination is requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ren_valid | input | 1 | An instruction is presented for renaming |
| ren_has_dst | input | 1 | The instruction writes a destination |
| ren_dst | input | 5 | Destination logical register |
| ren_src1 | input | 5 | First source logical register |
| ren_src2 | input | 5 | Second source logical register |
| ren_stall | output | 1 | Rename cannot be accepted this cycle |
| ren_src1_phys | output | 6 | Physical register of source 1 |
| ren_src1_busy | output | 1 | Source 1 value not yet produced |
| ren_src2_phys | output | 6 | Physical register of source 2 |
| ren_src2_busy | output | 1 | Source 2 value not yet produced |
| ren_dst_phys | output | 6 | Newly allocated physical register (0 when none) |
| ren_dst_old_phys | output | 6 | Previous mapping of the destination |
| cmp_valid | input | 1 | An instruction finished execution |
| cmp_phys | input | 6 | Physical register whose busy bit clears |
| rel_valid | input | 1 | A physical register is returned at retirement |
| rel_phys | input | 6 | Physical register returned to the free list |

## Verification
A corrupted map entry shows up as a wrong source register on the first lookup of that logical register. It also shows up as a wrong old mapping on that register's next rename. A free-list pointer or order fault shows on the very next allocation as an out-of-sequence destination. A count fault shows as a stall that is missing or spurious. A busy-bit fault stays hidden until a source reads that register, so the sweep reads every logical register right after reset and reads a mix of registers on each renaming cycle. The goal is to expose a fault within a few cycles.

// File: rtl/rename_pkg.sv
package rename_pkg;

    typedef enum logic [1:0] {
        FL_EMPTY = 2'd0,
        FL_PART  = 2'd1,
        FL_FULL  = 2'd2
    } fl_state_e;

endpackage

// File: rtl/rename_map_table.sv
module rename_map_table #(
    parameter int LOG_REGS  = 32,
    parameter int PHYS_REGS = 64,
    localparam int LW = $clog2(LOG_REGS),
    localparam int PW = $clog2(PHYS_REGS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [LW-1:0] rd_a_idx,
    input  logic [LW-1:0] rd_b_idx,
    input  logic [LW-1:0] rd_c_idx,
    output logic [PW-1:0] rd_a_phys,
    output logic [PW-1:0] rd_b_phys,
    output logic [PW-1:0] rd_c_phys,
    input  logic          wr_en,
    input  logic [LW-1:0] wr_idx,
    input  logic [PW-1:0] wr_phys
);

    logic [PW-1:0] map_q [LOG_REGS];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < LOG_REGS; i++) begin
                map_q[i] <= PW'(i);
            end
        end else if (wr_en) begin
            map_q[wr_idx] <= wr_phys;
        end
    end

    // Reads see the table before this cycle's write.
    always_comb begin
        rd_a_phys = map_q[rd_a_idx];
        rd_b_phys = map_q[rd_b_idx];
        rd_c_phys = map_q[rd_c_idx];
    end

endmodule

// File: rtl/rename_free_list.sv
module rename_free_list
    import rename_pkg::*;
#(
    parameter int LOG_REGS  = 32,
    parameter int PHYS_REGS = 64,
    localparam int PW    = $clog2(PHYS_REGS),
    localparam int DEPTH = PHYS_REGS - LOG_REGS,
    localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pop,
    input  logic          push,
    input  logic [PW-1:0] push_phys,
    output logic [PW-1:0] head_phys,
    output logic          empty,
    output logic          full,
    output logic [CW-1:0] count
);

    logic [PW-1:0] slot_q [DEPTH];
    logic [AW-1:0] rd_ptr_q, wr_ptr_q;
    logic [CW-1:0] count_q, count_d;
    fl_state_e     state_q, state_d;
    logic          do_pop, do_push;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    assign do_pop  = pop && !empty;
    assign do_push = push && !full;
    assign count_d = count_q + CW'(do_push) - CW'(do_pop);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= FL_FULL;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FL_EMPTY: if (do_push) state_d = (count_d == CW'(DEPTH)) ? FL_FULL : FL_PART;
            FL_PART: begin
                if (count_d == '0)              state_d = FL_EMPTY;
                else if (count_d == CW'(DEPTH)) state_d = FL_FULL;
            end
            FL_FULL:  if (do_pop && !do_push) state_d = (count_d == '0) ? FL_EMPTY : FL_PART;
            default:  state_d = FL_EMPTY;
        endcase
    end

    // Outputs
    always_comb begin
        empty     = (state_q == FL_EMPTY);
        full      = (state_q == FL_FULL);
        head_phys = slot_q[rd_ptr_q];
        count     = count_q;
    end

    // Storage and pointers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < DEPTH; k++) begin
                slot_q[k] <= PW'(LOG_REGS + k);
            end
            rd_ptr_q <= '0;
            wr_ptr_q <= '0;
            count_q  <= CW'(DEPTH);
        end else begin
            if (do_push) begin
                slot_q[wr_ptr_q] <= push_phys;
                wr_ptr_q         <= bump(wr_ptr_q);
            end
            if (do_pop) begin
                rd_ptr_q <= bump(rd_ptr_q);
            end
            count_q <= count_d;
        end
    end

endmodule

// File: rtl/rename_busy_vec.sv
module rename_busy_vec #(
    parameter int PHYS_REGS = 64,
    localparam int PW = $clog2(PHYS_REGS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 set_en,
    input  logic [PW-1:0]        set_idx,
    input  logic                 clr_en,
    input  logic [PW-1:0]        clr_idx,
    input  logic [PW-1:0]        rd_a_idx,
    input  logic [PW-1:0]        rd_b_idx,
    output logic                 rd_a_busy,
    output logic                 rd_b_busy,
    output logic [PHYS_REGS-1:0] busy_bits
);

    logic [PHYS_REGS-1:0] busy_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= '0;
        end else begin
            if (clr_en) busy_q[clr_idx] <= 1'b0;
            if (set_en) busy_q[set_idx] <= 1'b1;  // a new allocation wins
        end
    end

    always_comb begin
        rd_a_busy = busy_q[rd_a_idx];
        rd_b_busy = busy_q[rd_b_idx];
        busy_bits = busy_q;
    end

endmodule

// File: rtl/rename_unit.sv
module rename_unit #(
    parameter int LOG_REGS  = 32,
    parameter int PHYS_REGS = 64,
    localparam int LW = $clog2(LOG_REGS),
    localparam int PW = $clog2(PHYS_REGS),
    localparam int CW = $clog2(PHYS_REGS - LOG_REGS + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ren_valid,
    input  logic          ren_has_dst,
    input  logic [LW-1:0] ren_dst,
    input  logic [LW-1:0] ren_src1,
    input  logic [LW-1:0] ren_src2,
    output logic          ren_stall,
    output logic [PW-1:0] ren_src1_phys,
    output logic          ren_src1_busy,
    output logic [PW-1:0] ren_src2_phys,
    output logic          ren_src2_busy,
    output logic [PW-1:0] ren_dst_phys,
    output logic [PW-1:0] ren_dst_old_phys,
    input  logic          cmp_valid,
    input  logic [PW-1:0] cmp_phys,
    input  logic          rel_valid,
    input  logic [PW-1:0] rel_phys
);

    logic                 needs_dst, alloc;
    logic                 fl_empty, fl_full;
    logic [CW-1:0]        fl_count;
    logic [PW-1:0]        head_phys;
    logic [PW-1:0]        map_s1, map_s2, map_dst;
    logic                 busy_s1, busy_s2;
    logic [PHYS_REGS-1:0] busy_vec;

    assign needs_dst = ren_has_dst && (ren_dst != '0);
    assign alloc     = ren_valid && needs_dst && !fl_empty;

    rename_map_table #(.LOG_REGS(LOG_REGS), .PHYS_REGS(PHYS_REGS)) u_map (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_a_idx (ren_src1),
        .rd_b_idx (ren_src2),
        .rd_c_idx (ren_dst),
        .rd_a_phys(map_s1),
        .rd_b_phys(map_s2),
        .rd_c_phys(map_dst),
        .wr_en    (alloc),
        .wr_idx   (ren_dst),
        .wr_phys  (head_phys)
    );

    rename_free_list #(.LOG_REGS(LOG_REGS), .PHYS_REGS(PHYS_REGS)) u_free (
        .clk      (clk),
        .rst_n    (rst_n),
        .pop      (alloc),
        .push     (rel_valid),
        .push_phys(rel_phys),
        .head_phys(head_phys),
        .empty    (fl_empty),
        .full     (fl_full),
        .count    (fl_count)
    );

    rename_busy_vec #(.PHYS_REGS(PHYS_REGS)) u_busy (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_en   (alloc),
        .set_idx  (head_phys),
        .clr_en   (cmp_valid),
        .clr_idx  (cmp_phys),
        .rd_a_idx (map_s1),
        .rd_b_idx (map_s2),
        .rd_a_busy(busy_s1),
        .rd_b_busy(busy_s2),
        .busy_bits(busy_vec)
    );

    always_comb begin
        ren_stall        = ren_valid && needs_dst && fl_empty;
        ren_src1_phys    = (ren_src1 == '0) ? '0 : map_s1;
        ren_src1_busy    = (ren_src1 == '0) ? 1'b0 : busy_s1;
        ren_src2_phys    = (ren_src2 == '0) ? '0 : map_s2;
        ren_src2_busy    = (ren_src2 == '0) ? 1'b0 : busy_s2;
        ren_dst_phys     = alloc ? head_phys : '0;
        ren_dst_old_phys = needs_dst ? map_dst : '0;
    end

endmodule

// File: rtl/rename_unit_checker.sv
module rename_unit_checker #(
    parameter int LOG_REGS  = 32,
    parameter int PHYS_REGS = 64,
    localparam int LW    = $clog2(LOG_REGS),
    localparam int PW    = $clog2(PHYS_REGS),
    localparam int DEPTH = PHYS_REGS - LOG_REGS,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 ren_valid,
    input logic                 ren_has_dst,
    input logic [LW-1:0]        ren_dst,
    input logic [LW-1:0]        ren_src1,
    input logic [PW-1:0]        ren_src1_phys,
    input logic                 ren_src1_busy,
    input logic                 ren_stall,
    input logic [PW-1:0]        ren_dst_phys,
    input logic                 cmp_valid,
    input logic [PW-1:0]        cmp_phys,
    input logic                 rel_valid,
    input logic [CW-1:0]        fl_count,
    input logic [PHYS_REGS-1:0] busy_vec
);

    logic took;
    assign took = ren_valid && ren_has_dst && (ren_dst != '0) && !ren_stall;

    assert_zero_src_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ren_src1 == '0) |-> (ren_src1_phys == '0 && !ren_src1_busy));

    assert_stall_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ren_stall |-> (fl_count == '0));

    assert_alloc_nonzero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        took |-> (ren_dst_phys >= PW'(1)));

    assert_alloc_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        took |=> busy_vec[$past(ren_dst_phys)]);

    assert_clear_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_valid && !(took && ren_dst_phys == cmp_phys)) |=> !busy_vec[$past(cmp_phys)]);

    assert_map_visible_R3: assert property (@(posedge clk) disable iff (!rst_n)
        took |=> (ren_src1 != $past(ren_dst) || ren_src1_phys == $past(ren_dst_phys)));

    assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rel_valid |-> (fl_count < CW'(DEPTH)));

endmodule

bind rename_unit rename_unit_checker #(.LOG_REGS(LOG_REGS), .PHYS_REGS(PHYS_REGS)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .ren_valid    (ren_valid),
    .ren_has_dst  (ren_has_dst),
    .ren_dst      (ren_dst),
    .ren_src1     (ren_src1),
    .ren_src1_phys(ren_src1_phys),
    .ren_src1_busy(ren_src1_busy),
    .ren_stall    (ren_stall),
    .ren_dst_phys (ren_dst_phys),
    .cmp_valid    (cmp_valid),
    .cmp_phys     (cmp_phys),
    .rel_valid    (rel_valid),
    .fl_count     (fl_count),
    .busy_vec     (busy_vec)
);

// File: tb/rename_unit_bench.sv
`timescale 1ns/1ps
module rename_unit_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ren_valid = 1'b0, ren_has_dst = 1'b0;
    logic [4:0] ren_dst = '0, ren_src1 = '0, ren_src2 = '0;
    logic       ren_stall, ren_src1_busy, ren_src2_busy;
    logic [5:0] ren_src1_phys, ren_src2_phys, ren_dst_phys, ren_dst_old_phys;
    logic       cmp_valid = 1'b0, rel_valid = 1'b0;
    logic [5:0] cmp_phys = '0, rel_phys = '0;

    always #2.5 clk = ~clk;

    rename_unit u_rename_unit (
        .clk(clk), .rst_n(rst_n),
        .ren_valid(ren_valid), .ren_has_dst(ren_has_dst), .ren_dst(ren_dst),
        .ren_src1(ren_src1), .ren_src2(ren_src2), .ren_stall(ren_stall),
        .ren_src1_phys(ren_src1_phys), .ren_src1_busy(ren_src1_busy),
        .ren_src2_phys(ren_src2_phys), .ren_src2_busy(ren_src2_busy),
        .ren_dst_phys(ren_dst_phys), .ren_dst_old_phys(ren_dst_old_phys),
        .cmp_valid(cmp_valid), .cmp_phys(cmp_phys),
        .rel_valid(rel_valid), .rel_phys(rel_phys)
    );

    int    n_checks = 0, n_errors = 0;
    bit    finished = 0;
    string tag_force = "";
    int    mmap[32];
    bit    mbusy[64];
    int    fq[$], rq[$], cq[$];

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    endtask

    task automatic step(input bit v, input int s1, input int s2, input int d, input bit hd,
                        input bit cv, input int cp, input bit rv, input int rp);
        bit need, stall, take;
        int e1, e2, b1, b2, nw, old;
        @(negedge clk);
        ren_valid = v; ren_src1 = 5'(s1); ren_src2 = 5'(s2); ren_dst = 5'(d); ren_has_dst = hd;
        cmp_valid = cv; cmp_phys = 6'(cp); rel_valid = rv; rel_phys = 6'(rp);
        #1;
        need  = hd && (d != 0);
        stall = v && need && (fq.size() == 0);
        take  = v && need && (fq.size() != 0);
        e1 = (s1 == 0) ? 0 : mmap[s1];
        e2 = (s2 == 0) ? 0 : mmap[s2];
        b1 = (s1 == 0) ? 0 : int'(mbusy[e1]);
        b2 = (s2 == 0) ? 0 : int'(mbusy[e2]);
        check(ren_stall == stall, (tag_force != "") ? tag_force : "R6", ren_stall, stall);
        check(ren_src1_phys == 6'(e1),
              (tag_force != "") ? tag_force : (s1 == 0) ? "R7" : (need && s1 == d) ? "R8" : "R2",
              ren_src1_phys, e1);
        check(ren_src2_phys == 6'(e2), (tag_force != "") ? tag_force : (s2 == 0) ? "R7" : "R2",
              ren_src2_phys, e2);
        check(ren_src1_busy == b1[0], (tag_force != "") ? tag_force : "R4", ren_src1_busy, b1);
        check(ren_src2_busy == b2[0], (tag_force != "") ? tag_force : "R4", ren_src2_busy, b2);
        if (need) begin
            old = mmap[d];
            check(ren_dst_old_phys == 6'(old), "R10", ren_dst_old_phys, old);
        end
        if (take) begin
            nw = fq[0];
            check(ren_dst_phys == 6'(nw), (tag_force != "") ? tag_force : "R1", ren_dst_phys, nw);
        end
        // model update for the coming edge (R3, R4, R9)
        if (take) begin
            void'(fq.pop_front());
            rq.push_back(mmap[d]);
            cq.push_back(nw);
            mmap[d] = nw;
        end
        if (rv) fq.push_back(rp);
        if (cv) mbusy[cp] = 0;
        if (take) mbusy[nw] = 1;
    endtask

    initial begin
        #(5.0 * 200000);
        n_errors++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        for (int i = 0; i < 32; i++) mmap[i] = i;
        for (int i = 0; i < 64; i++) mbusy[i] = 0;
        for (int i = 32; i < 64; i++) fq.push_back(i);
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R5: identity map and nothing busy after reset
        tag_force = "R5";
        for (int i = 0; i < 32; i++) step(0, i, 31 - i, 0, 0, 0, 0, 0, 0);
        tag_force = "";

        // R1/R8: rename r1..r31 in order, each reading its own destination
        for (int i = 1; i < 32; i++) step(1, i, 0, i, 1, 0, 0, 0, 0);
        // R3/R4: every register now remapped and busy
        for (int i = 0; i < 32; i++) step(0, i, (i + 5) % 32, 0, 0, 0, 0, 0, 0);
        // R7: destination 0 never allocates
        step(1, 0, 0, 0, 1, 0, 0, 0, 0);
        // drain the last entry, then R6 stall with and without release
        step(1, 1, 2, 1, 1, 0, 0, 0, 0);
        step(1, 3, 4, 2, 1, 0, 0, 0, 0);
        step(1, 3, 4, 2, 0, 0, 0, 0, 0);
        tag_force = "R9";
        step(1, 3, 4, 2, 1, 0, 0, 1, rq.pop_front());
        step(1, 2, 5, 2, 1, 0, 0, 0, 0);
        tag_force = "";
        // R4: complete the register now mapped to r1, then read it
        step(0, 1, 2, 0, 0, 1, mmap[1], 0, 0);
        step(0, 1, 2, 0, 0, 0, 0, 0, 0);

        // mixed sweep with completions and releases
        for (int k = 0; k < 400; k++) begin
            bit cv, rv;
            int cp, rp;
            cv = (k % 3 != 0) && (cq.size() != 0);
            cp = cv ? cq.pop_front() : 0;
            rv = (k % 4 < 2) && (rq.size() != 0);
            rp = rv ? rq.pop_front() : 0;
            step(k % 5 != 4, (k * 11) % 32, (k * 13 + 1) % 32, (k * 7 + 3) % 32,
                 k % 6 != 5, cv, cp, rv, rp);
        end
        step(0, 0, 0, 0, 0, 0, 0, 0, 0);
        finish_run();
    end

endmodule